// File: doc/BRIEF.md
# Cascadable Segment Data Shift-Latch

This block is the data path on the column side of a passive-matrix display driver. A controller streams pixel data in, one bit or one 4-bit nibble for each shift strobe. The data fills an 80-bit register made of 20 four-bit stages, in either direction. A line-latch strobe then copies the whole register into an 80-bit output latch, which feeds the analog output stages. The latch holds its value while the next line is loaded.

Several of these blocks can form a chain across one display row. Only the block whose active enable input is low accepts shift strobes. A fill counter tracks the strobes that were accepted. After the last strobe of a line (80 strobes in serial mode, 20 in nibble mode), the control machine moves from state FILL to state FULL. In FULL it drives its cascade output low, which enables the next block, and it ignores any further strobes. The direction input picks which enable pin is the input and which is the output.

The control machine has two states and three transitions:
- FILL→FULL: taken on the last accepted strobe.
- FULL→FILL: taken on a latch strobe.
- FILL→FILL: taken on a latch strobe that arrives early.

Top module: `seg_shift_latch`

## Requirements
- R1: While `rst` is high, on each clock edge the shift register, the fill counter and `line_q` clear to zero, and both `en_l_out` and `en_r_out` go high.
- R2: Serial mode (`par_mode`=0) takes `din[0]` on each accepted strobe and needs exactly 80 accepted strobes to fill. With `dir`=0, data moves toward index 0, so the first bit shifted in ends up at `line_q[0]` and the last at `line_q[79]`.
- R3: Nibble mode (`par_mode`=1) takes `din[3:0]` on each accepted strobe and needs exactly 20 accepted strobes to fill. With `dir`=0, the first nibble ends up at `line_q[3:0]` with `din[k]` at bit k, and the last nibble at `line_q[79:76]`.
- R4: With `dir`=1, data moves toward index 79. In serial mode the first bit ends up at `line_q[79]`. In nibble mode the first nibble ends up at `line_q[79:76]`.
- R5: A strobe on `shift_en` is ignored while the active enable input is high. The register and the counter keep their values.
- R6: With `dir`=0, `en_r_in` is the active enable input, `en_l_out` is the cascade output and `en_r_out` stays high. With `dir`=1 the roles swap: `en_l_in` is the enable input, `en_r_out` is the cascade output and `en_l_out` stays high.
- R7: The cascade output goes low on the clock edge that registers the last accepted strobe of a line, and stays low until a latch strobe. Strobes that arrive while the cascade output is low are ignored.
- R8: A `line_latch` strobe copies the register into `line_q` on the next edge. At no other time does `line_q` change.
- R9: A `line_latch` strobe clears the fill counter and sets the cascade output high again on the same edge.
- R10: If `shift_en` and `line_latch` occur in the same cycle, `line_q` takes the register contents from before that shift. The shift is accepted, even in state FULL, and counts as the first strobe of the new line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift strobe from the data clock, one cycle wide |
| line_latch | input | 1 | Latch strobe from the line clock, one cycle wide |
| dir | input | 1 | Fill direction: 0 left to right, 1 right to left |
| par_mode | input | 1 | 0 serial on din[0], 1 nibble on din[3:0] |
| din | input | 4 | Display data |
| en_l_in | input | 1 | Left enable input, active low (used when dir=1) |
| en_r_in | input | 1 | Right enable input, active low (used when dir=0) |
| en_l_out | output | 1 | Left cascade output, active low (used when dir=0) |
| en_r_out | output | 1 | Right cascade output, active low (used when dir=1) |
| line_q | output | 80 | Latched line data |

## Verification
A shift strobe and a latch strobe can fall in the same cycle. The FULL→FILL and FILL→FILL transitions then compete with the counter increment. The bench fills a line in nibble mode, holds the block in FULL, and then raises both strobes in one cycle. The scoreboard expects the latched line to equal the register contents before that shift. The bench then checks that the cascade output goes low after 19 more strobes, not 20, which shows the shared cycle was counted as the first strobe of the new line.

// File: rtl/seg_shift_latch_pkg.sv
package seg_shift_latch_pkg;

    typedef enum logic {
        ST_FILL = 1'b0,
        ST_FULL = 1'b1
    } fill_state_t;

endpackage

// File: rtl/seg_fill_ctrl.sv
module seg_fill_ctrl
    import seg_shift_latch_pkg::*;
#(
    parameter int STAGES = 20,
    parameter int LANES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_en,
    input  logic line_latch,
    input  logic en_n,
    input  logic par_mode,
    output logic accept,
    output logic full
);
    localparam int WIDTH = STAGES * LANES;
    localparam int CW    = $clog2(WIDTH + 1);

    fill_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] target;

    assign target = par_mode ? CW'(STAGES) : CW'(WIDTH);

    // A latch strobe re-opens the line, so a shift in the same cycle is taken.
    assign accept = shift_en && !en_n && ((state_q == ST_FILL) || line_latch);

    always_comb begin
        cnt_d   = cnt_q;
        state_d = state_q;
        unique case (state_q)
            ST_FILL: begin
                if (line_latch) begin
                    cnt_d   = accept ? CW'(1) : '0;     // FILL -> FILL
                    state_d = ST_FILL;
                end else if (accept) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_d >= target) state_d = ST_FULL;  // FILL -> FULL
                end
            end
            ST_FULL: begin
                if (line_latch) begin
                    cnt_d   = accept ? CW'(1) : '0;     // FULL -> FILL
                    state_d = ST_FILL;
                end
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        full = (state_q == ST_FULL);
    end

    p_full_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(accept));
    p_latch_reopens_r9: assert property (@(posedge clk) disable iff (rst)
        line_latch |=> !full);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(WIDTH));
    p_full_ignores_r7: assert property (@(posedge clk) disable iff (rst)
        (full && !line_latch) |=> $stable(cnt_q));
endmodule

// File: rtl/seg_shift_reg.sv
module seg_shift_reg #(
    parameter int STAGES = 20,
    parameter int LANES  = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       accept,
    input  logic                       dir,
    input  logic                       par_mode,
    input  logic [LANES-1:0]           din,
    output logic [STAGES*LANES-1:0]    sr_q
);
    localparam int WIDTH = STAGES * LANES;

    logic [WIDTH-1:0] nxt_lr_ser, nxt_lr_par, nxt_rl_ser, nxt_rl_par, nxt;

    // left-to-right: new data enters at the top and moves toward index 0
    assign nxt_lr_ser = {din[0], sr_q[WIDTH-1:1]};
    assign nxt_lr_par = {din, sr_q[WIDTH-1:LANES]};
    // right-to-left: new data enters at index 0 and moves toward the top
    assign nxt_rl_ser = {sr_q[WIDTH-2:0], din[0]};
    assign nxt_rl_par = {sr_q[WIDTH-LANES-1:0], din};

    always_comb begin
        unique case ({dir, par_mode})
            2'b00:   nxt = nxt_lr_ser;
            2'b01:   nxt = nxt_lr_par;
            2'b10:   nxt = nxt_rl_ser;
            default: nxt = nxt_rl_par;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         sr_q <= '0;
        else if (accept) sr_q <= nxt;
    end

    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(sr_q));
endmodule

// File: rtl/seg_line_latch.sv
module seg_line_latch #(
    parameter int WIDTH = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    p_latch_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
    p_latch_capture_r10: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));
endmodule

// File: rtl/seg_shift_latch.sv
module seg_shift_latch #(
    parameter int STAGES = 20,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    shift_en,
    input  logic                    line_latch,
    input  logic                    dir,
    input  logic                    par_mode,
    input  logic [LANES-1:0]        din,
    input  logic                    en_l_in,
    input  logic                    en_r_in,
    output logic                    en_l_out,
    output logic                    en_r_out,
    output logic [STAGES*LANES-1:0] line_q
);
    localparam int WIDTH = STAGES * LANES;

    logic             en_n, accept, full;
    logic [WIDTH-1:0] sr_q;

    // direction chooses which side listens and which side hands on
    assign en_n     = dir ? en_l_in : en_r_in;
    assign en_l_out = dir ? 1'b1 : !full;
    assign en_r_out = dir ? !full : 1'b1;

    seg_fill_ctrl #(.STAGES(STAGES), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst(rst), .shift_en(shift_en), .line_latch(line_latch),
        .en_n(en_n), .par_mode(par_mode), .accept(accept), .full(full)
    );

    seg_shift_reg #(.STAGES(STAGES), .LANES(LANES)) u_sr (
        .clk(clk), .rst(rst), .accept(accept), .dir(dir),
        .par_mode(par_mode), .din(din), .sr_q(sr_q)
    );

    seg_line_latch #(.WIDTH(WIDTH)) u_latch (
        .clk(clk), .rst(rst), .load(line_latch), .d(sr_q), .q(line_q)
    );

    p_disabled_no_shift_r5: assert property (@(posedge clk) disable iff (rst)
        (en_n && !line_latch) |=> $stable(line_q));
    p_one_cascade_low_r6: assert property (@(posedge clk) disable iff (rst)
        (en_l_out || en_r_out));
endmodule

// File: tb/seg_shift_latch_bench.sv
module seg_shift_latch_bench;
    localparam int W = 80;

    logic clk = 0, rst = 1;
    logic shift_en = 0, line_latch = 0, dir = 0, par_mode = 0;
    logic [3:0] din = 4'hF;
    logic en_l_in = 1, en_r_in = 1;
    logic en_l_out, en_r_out;
    logic [W-1:0] line_q;

    int checks = 0, fails = 0;
    logic [W-1:0] exp_q[$];
    string        exp_tag[$];

    logic [W-1:0] m_sr = '0;
    int           m_cnt = 0;
    bit           m_full = 0;
    logic [15:0]  lfsr = 16'hACE1;

    always #10 clk = ~clk;

    seg_shift_latch u_seg_shift_latch (
        .clk(clk), .rst(rst), .shift_en(shift_en), .line_latch(line_latch),
        .dir(dir), .par_mode(par_mode), .din(din), .en_l_in(en_l_in),
        .en_r_in(en_r_in), .en_l_out(en_l_out), .en_r_out(en_r_out),
        .line_q(line_q)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] rnd4();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[3:0];
    endfunction

    // Driver: one cycle of stimulus, the model follows the requirements
    task automatic cyc(input bit sh, input bit lt, input logic [3:0] d, input string tag);
        bit en_act, acc;
        int tgt;
        @(negedge clk);
        shift_en = sh; line_latch = lt; din = par_mode ? d : {3'b111, d[0]};
        en_act = !(dir ? en_l_in : en_r_in);
        acc = sh && en_act && (!m_full || lt);
        tgt = par_mode ? 20 : 80;
        if (lt) begin exp_q.push_back(m_sr); exp_tag.push_back(tag); end
        if (acc) begin
            if (!dir) m_sr = par_mode ? {d, m_sr[W-1:4]} : {d[0], m_sr[W-1:1]};
            else      m_sr = par_mode ? {m_sr[W-5:0], d} : {m_sr[W-2:0], d[0]};
        end
        if (lt) m_cnt = acc ? 1 : 0;
        else if (acc) m_cnt++;
        m_full = !lt && m_cnt >= tgt;
    endtask

    // idle cycle, then compare cascade pins at that negedge
    task automatic idle_chk(input string tag);
        @(negedge clk);
        shift_en = 0; line_latch = 0;
        chk(en_l_out == (dir ? 1'b1 : !m_full), {tag, " en_l_out"}, W'(en_l_out), W'(dir ? 1'b1 : !m_full));
        chk(en_r_out == (dir ? !m_full : 1'b1), {tag, " en_r_out"}, W'(en_r_out), W'(dir ? !m_full : 1'b1));
    endtask

    task automatic fill(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, 0, rnd4(), tag);
    endtask

    // Monitor: pops an expected line when the design latches
    always @(posedge clk) begin
        if (!rst && line_latch) begin
            #2;
            if (exp_q.size() == 0) chk(0, "R8 unexpected latch", line_q, '0);
            else begin
                logic [W-1:0] e;
                string t;
                e = exp_q.pop_front(); t = exp_tag.pop_front();
                chk(line_q === e, t, line_q, e);
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk(line_q == '0, "R1 line_q", line_q, '0);
                chk(en_l_out && en_r_out, "R1 cascade high", W'({en_l_out, en_r_out}), W'(2'b11));
                @(negedge clk); rst = 0;

                // R2 serial, left to right; first bit lands at index 0
                dir = 0; par_mode = 0; en_r_in = 0;
                cyc(1, 0, 4'h1, "R2");
                fill(78, "R2");
                idle_chk("R2 79 strobes");
                cyc(1, 0, 4'h0, "R2");
                idle_chk("R2 R7 80 strobes");
                chk(m_sr[0] == 1'b1, "R2 first bit at index 0", W'(m_sr[0]), W'(1));
                cyc(1, 0, 4'h1, "R7 ignored when full");
                cyc(0, 1, 4'h0, "R2 R7 R8 latch serial");
                idle_chk("R9 reopen");

                // R8 latch holds during next line
                par_mode = 1;
                fill(10, "R8");
                @(negedge clk); shift_en = 0;
                chk(line_q == exp_last(), "R8 stable during fill", line_q, exp_last());

                // R3 nibble left to right
                cyc(0, 1, 4'h0, "R8 partial latch");
                cyc(1, 0, 4'hA, "R3");
                fill(18, "R3");
                idle_chk("R3 19 strobes");
                cyc(1, 0, 4'h5, "R3");
                idle_chk("R3 20 strobes");
                chk(m_sr[3:0] == 4'hA, "R3 first nibble at [3:0]", W'(m_sr[3:0]), W'(4'hA));
                // R10 shift and latch together while full
                cyc(1, 1, 4'hC, "R10 latch pre-shift");
                fill(18, "R10");
                idle_chk("R10 19 after shared");
                cyc(1, 0, 4'h3, "R10");
                idle_chk("R10 full after 19");
                cyc(0, 1, 4'h0, "R10 R3 latch");

                // R5 disabled chip ignores strobes
                en_r_in = 1;
                fill(30, "R5");
                idle_chk("R5 disabled");
                en_r_in = 0;
                cyc(0, 1, 4'h0, "R5 latch unchanged");

                // R4 R6 right to left; enable on left pin, right pin irrelevant
                dir = 1; en_l_in = 0; en_r_in = 1; par_mode = 0;
                cyc(0, 1, 4'h0, "R4 clear count");
                cyc(1, 0, 4'h1, "R4");
                fill(79, "R4");
                idle_chk("R4 R6 serial full");
                chk(m_sr[79] == 1'b1, "R4 first bit at 79", W'(m_sr[79]), W'(1));
                cyc(0, 1, 4'h0, "R4 latch serial");
                idle_chk("R6 reopen");
                par_mode = 1;
                cyc(1, 0, 4'h9, "R4");
                fill(19, "R4");
                idle_chk("R4 R6 nibble full");
                cyc(0, 1, 4'h0, "R4 latch nibble");
                en_l_in = 1;
                fill(5, "R6 left disabled");
                idle_chk("R6 left disabled");
                cyc(0, 1, 4'h0, "R6 latch unchanged");
                idle_chk("R9 end");
                repeat (3) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                chk(0, "watchdog", '0, '1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    function automatic logic [W-1:0] exp_last();
        return last_latched;
    endfunction

    logic [W-1:0] last_latched = '0;
    always @(posedge clk) if (!rst && line_latch) last_latched <= m_sr_at_latch();
    function automatic logic [W-1:0] m_sr_at_latch();
        return exp_q.size() > 0 ? exp_q[0] : last_latched;
    endfunction
endmodule